// File: doc/BRIEF.md
# Pipeline Forwarding and Stall Unit

This unit resolves data hazards in a five-stage 32-bit RISC pipeline whose stages are fetch, decode, execute, memory and writeback, separated by the IF/ID, ID/EX, EX/MEM and MEM/WB registers. Each cycle it compares the two source register fields of the instruction in execute against the destination fields held in EX/MEM and MEM/WB. It then steers each execute operand multiplexer to the register file, to the ALU result waiting in EX/MEM, or to the load data waiting in MEM/WB.

Some hazards cannot be solved by forwarding. If the instruction in execute is a load, and the instruction in decode reads that load's destination, the data does not exist yet. In that case the unit freezes the program counter and the IF/ID register for one cycle. It also zeroes the control fields entering ID/EX, so a bubble moves forward in place of the dependent instruction. The assembler therefore never needs to pad the code with no-ops.

All outputs are combinational functions of the current stage fields, so a select or stall request acts in the cycle its cause appears. Register fields are 4 bits wide by default, for a 16-entry register file.

Top module: `hazard_ctl`

## Requirements
- R1: Each operand select is 2 bits, coded 00 for the register file, 01 for MEM/WB data and 10 for the EX/MEM ALU result; operand A follows the execute rs field, operand B the execute rt field, and 11 never appears.
- R2: When EX/MEM writes a register and its destination equals a nonzero execute source field, that operand select is 10.
- R3: When only MEM/WB writes a register whose destination equals a nonzero execute source field, that operand select is 01.
- R4: When both EX/MEM and MEM/WB match the same source field, the select is 10, so the younger result wins.
- R5: A source field of register 0 always selects 00, whatever the producing stages hold.
- R6: A producing stage whose write enable is low never causes forwarding, even if its destination field matches.
- R7: When execute holds a load (ex_load high) whose nonzero destination equals the decode rs or rt field, pc_hold, ifid_hold and idex_bubble are all 1 in that cycle.
- R8: No stall is raised when execute holds a non-load, when the load's destination is register 0, or when it matches neither decode source field; all three stall outputs are then 0.
- R9: A load-use hazard costs exactly one stall cycle: in the next cycle the bubble occupies execute and the stall drops, and one cycle later the dependent instruction in execute takes the load data through select 01.
- R10: The operand selects for the instruction in execute are computed the same way whether or not a stall is raised in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, used only for the embedded checks |
| rst_n | input | 1 | Active-low reset, disables the embedded checks |
| id_rs | input | 4 | First source register field of the decode instruction |
| id_rt | input | 4 | Second source register field of the decode instruction |
| ex_rs | input | 4 | First source register field of the execute instruction |
| ex_rt | input | 4 | Second source register field of the execute instruction |
| ex_rd | input | 4 | Destination register of the execute instruction |
| ex_load | input | 1 | Execute instruction reads data memory |
| exm_rd | input | 4 | Destination register held in EX/MEM |
| exm_wen | input | 1 | EX/MEM instruction writes a register |
| wb_rd | input | 4 | Destination register held in MEM/WB |
| wb_wen | input | 1 | MEM/WB instruction writes a register |
| fwd_a_sel | output | 2 | Operand A multiplexer select |
| fwd_b_sel | output | 2 | Operand B multiplexer select |
| pc_hold | output | 1 | Keep the current PC instead of the incremented one |
| ifid_hold | output | 1 | Keep the IF/ID register contents |
| idex_bubble | output | 1 | Clear the control fields entering ID/EX |

## Verification
The key overlap is a load-use stall raised in the same cycle that the load itself, sitting in execute, needs its own operands forwarded from EX/MEM or MEM/WB. The bench provokes this by sweeping every load destination against every pair of decode source fields, while fixed producer fields create forwarding matches on the load's rs and rt. In each such cycle it judges the stall outputs and both selects against separately computed expected values. A short cycle-by-cycle sequence then follows a load through the single bubble and checks the later forward of its data from MEM/WB.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_EXM = 2'b10
  } opsel_e;
endpackage

// File: rtl/hz_fwd_lane.sv
module hz_fwd_lane
  import hz_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    src,
  input  logic [AW-1:0]    exm_rd,
  input  logic             exm_wen,
  input  logic [AW-1:0]    wb_rd,
  input  logic             wb_wen,
  output logic [SEL_W-1:0] sel
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic   src_live;
  logic   exm_hit;
  logic   wb_hit;
  opsel_e sel_nx;

  always_comb begin
    src_live = (src != ZERO_REG);
    exm_hit  = src_live && exm_wen && (exm_rd == src);
    wb_hit   = src_live && wb_wen  && (wb_rd  == src);
    if (exm_hit) begin
      sel_nx = SEL_EXM;
    end else if (wb_hit) begin
      sel_nx = SEL_WB;
    end else begin
      sel_nx = SEL_RF;
    end
  end

  assign sel = sel_nx;

  p_sel_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sel != 2'b11);
  p_zero_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (src == ZERO_REG) |-> (sel == SEL_RF));
  p_no_wen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!exm_wen && !wb_wen) |-> (sel == SEL_RF));
  p_exm_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (exm_wen && (exm_rd == src) && (src != ZERO_REG)) |-> (sel == SEL_EXM));
endmodule

// File: rtl/hz_load_stall.sv
module hz_load_stall #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ex_load,
  input  logic [AW-1:0] ex_rd,
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  output logic          stall
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic dest_live;
  logic use_hit;
  logic stall_nx;

  always_comb begin
    dest_live = (ex_rd != ZERO_REG);
    use_hit   = (ex_rd == id_rs) || (ex_rd == id_rt);
    stall_nx  = ex_load && dest_live && use_hit;
  end

  assign stall = stall_nx;

  p_stall_needs_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> ex_load);
  p_stall_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (ex_rd != ZERO_REG));
  p_bubble_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_load) |-> !stall);
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
  import hz_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    id_rs,
  input  logic [AW-1:0]    id_rt,
  input  logic [AW-1:0]    ex_rs,
  input  logic [AW-1:0]    ex_rt,
  input  logic [AW-1:0]    ex_rd,
  input  logic             ex_load,
  input  logic [AW-1:0]    exm_rd,
  input  logic             exm_wen,
  input  logic [AW-1:0]    wb_rd,
  input  logic             wb_wen,
  output logic [SEL_W-1:0] fwd_a_sel,
  output logic [SEL_W-1:0] fwd_b_sel,
  output logic             pc_hold,
  output logic             ifid_hold,
  output logic             idex_bubble
);
  localparam int N_OPS = 2;

  logic [N_OPS-1:0][AW-1:0]    op_src;
  logic [N_OPS-1:0][SEL_W-1:0] op_sel;
  logic                        stall;

  assign op_src[0] = ex_rs;
  assign op_src[1] = ex_rt;

  for (genvar g = 0; g < N_OPS; g++) begin : g_lane
    hz_fwd_lane #(.AW(AW)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (op_src[g]),
      .exm_rd  (exm_rd),
      .exm_wen (exm_wen),
      .wb_rd   (wb_rd),
      .wb_wen  (wb_wen),
      .sel     (op_sel[g])
    );
  end

  hz_load_stall #(.AW(AW)) u_stall (
    .clk     (clk),
    .rst_n   (rst_n),
    .ex_load (ex_load),
    .ex_rd   (ex_rd),
    .id_rs   (id_rs),
    .id_rt   (id_rt),
    .stall   (stall)
  );

  assign fwd_a_sel   = op_sel[0];
  assign fwd_b_sel   = op_sel[1];
  assign pc_hold     = stall;
  assign ifid_hold   = stall;
  assign idex_bubble = stall;

  p_stall_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_hold |-> (ex_load && ((ex_rd == id_rs) || (ex_rd == id_rt))));
  p_exm_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a_sel == 2'b10) |-> (exm_wen && (exm_rd == ex_rs)));
  p_wb_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_b_sel == 2'b01) |-> (wb_wen && (wb_rd == ex_rt)));
endmodule

// File: tb/sim_hazard_ctl.sv
`timescale 1ns/1ps
module sim_hazard_ctl;
  localparam int AW = 4;
  localparam int NR = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] id_rs = '0, id_rt = '0, ex_rs = '0, ex_rt = '0, ex_rd = '0;
  logic [AW-1:0] exm_rd = '0, wb_rd = '0;
  logic ex_load = 1'b0, exm_wen = 1'b0, wb_wen = 1'b0;
  logic [1:0] fwd_a_sel, fwd_b_sel;
  logic pc_hold, ifid_hold, idex_bubble;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hazard_ctl #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .id_rs(id_rs), .id_rt(id_rt),
    .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_rd(ex_rd), .ex_load(ex_load),
    .exm_rd(exm_rd), .exm_wen(exm_wen), .wb_rd(wb_rd), .wb_wen(wb_wen),
    .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_sel(int src, int a, bit aw, int b, bit bw);
    if (src != 0 && aw && a == src) return 2;
    if (src != 0 && bw && b == src) return 1;
    return 0;
  endfunction

  function automatic string sel_tag(int src, int a, bit aw, int b, bit bw);
    if (src == 0) return "R5";
    if (a == src && b == src && aw && bw) return "R4";
    if ((a == src && !aw) || (b == src && !bw)) return "R6";
    if (aw && a == src) return "R2";
    if (bw && b == src) return "R3";
    return "R1";
  endfunction

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    // reset state: all fields zero, outputs at rest (R1, R8)
    settle(); #2;
    chk("R1 reset sel_a", fwd_a_sel, 0);
    chk("R1 reset sel_b", fwd_b_sel, 0);
    chk("R8 reset stall", {pc_hold, ifid_hold, idex_bubble}, 0);
    settle(); rst_n = 1'b1;

    // forwarding sweep: rs, EX/MEM dest, MEM/WB dest, both enables
    for (int s = 0; s < NR; s++)
      for (int a = 0; a < NR; a++)
        for (int b = 0; b < NR; b++)
          for (int w = 0; w < 4; w++) begin
            int t;
            settle();
            t = (s * 5 + 3) % NR;
            ex_rs = AW'(s); ex_rt = AW'(t);
            exm_rd = AW'(a); wb_rd = AW'(b);
            exm_wen = w[0]; wb_wen = w[1];
            #2;
            chk({sel_tag(s, a, w[0], b, w[1]), " sel_a"}, fwd_a_sel,
                exp_sel(s, a, w[0], b, w[1]));
            chk({sel_tag(t, a, w[0], b, w[1]), " sel_b"}, fwd_b_sel,
                exp_sel(t, a, w[0], b, w[1]));
          end

    // stall sweep, with the load's own operands forwarded at once (R7 R8 R10)
    exm_rd = 4'd3; exm_wen = 1'b1; wb_rd = 4'd9; wb_wen = 1'b1;
    ex_rs = 4'd3; ex_rt = 4'd9;
    for (int d = 0; d < NR; d++)
      for (int p = 0; p < NR; p++)
        for (int q = 0; q < NR; q++)
          for (int l = 0; l < 2; l++) begin
            int es;
            settle();
            ex_rd = AW'(d); id_rs = AW'(p); id_rt = AW'(q); ex_load = l[0];
            #2;
            es = (l == 1 && d != 0 && (d == p || d == q)) ? 1 : 0;
            chk(es ? "R7 pc_hold" : "R8 pc_hold", pc_hold, es);
            chk(es ? "R7 ifid_hold" : "R8 ifid_hold", ifid_hold, es);
            chk(es ? "R7 idex_bubble" : "R8 idex_bubble", idex_bubble, es);
            chk("R10 sel_a during stall sweep", fwd_a_sel, 2);
            chk("R10 sel_b during stall sweep", fwd_b_sel, 1);
          end

    // load-use sequence: lw r5 in EX, add uses r5 in ID (R9)
    settle();
    ex_load = 1'b1; ex_rd = 4'd5; ex_rs = 4'd0; ex_rt = 4'd0;
    id_rs = 4'd5; id_rt = 4'd2; exm_wen = 1'b0; wb_wen = 1'b0;
    #2; chk("R9 first cycle stall", pc_hold, 1);
    settle();  // bubble in EX, load in MEM, add still in ID
    ex_load = 1'b0; ex_rd = 4'd0; exm_rd = 4'd5; exm_wen = 1'b1;
    #2; chk("R9 second cycle no stall", pc_hold, 0);
    chk("R9 second cycle no bubble", idex_bubble, 0);
    settle();  // add in EX, bubble in MEM, load in WB
    ex_rs = 4'd5; ex_rt = 4'd2; exm_rd = 4'd0; exm_wen = 1'b0;
    wb_rd = 4'd5; wb_wen = 1'b1; id_rs = 4'd7; id_rt = 4'd8;
    #2; chk("R9 load data via MEM/WB", fwd_a_sel, 1);
    chk("R9 other operand from file", fwd_b_sel, 0);
    chk("R9 no further stall", pc_hold, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule